// File: doc/BRIEF.md
# Free-Running Time Base with Compare Interrupt

This block keeps a 56-bit count that advances by one on every cycle in which the `tick` input is high. It never stops and has no enable. Software sees the count through two read-only words on a 32-bit register bus. The low word holds bits 31:0 and the high word holds the remaining bits with zeros above them. Reads come from the live count and never hold the counter still. To get a consistent 56-bit value, software reads high, then low, then high again, and repeats if the two high values differ.

A second group of registers holds a 64-bit compare value and a control word with an enable bit and a mask bit. While enabled, a sticky status flag sets once the count, zero-extended to 64 bits, is at or above the compare value. The level interrupt is the status flag gated by enable and by the inverse of the mask. Software acknowledges the interrupt by writing the enable bit to zero, which also clears the status flag.

Top module: `syscnt_top`

## Requirements
- R1: After reset, every register reads zero (count words, both compare words and the control word) and `irq` is low.
- R2: The count rises by exactly one on each rising clock edge where `tick` is high and holds otherwise. Reads never delay it, so two reads on consecutive edges while `tick` is high return values that differ by one.
- R3: A read request at offset 0x08 returns count bits 31:0. A read request at 0x0C returns the upper count bits, zero-extended to 32 bits. `bus_rdata` shows the count as it stood at the request edge, from the cycle after that edge onward.
- R4: Offsets 0x20 and 0x24 hold the low and high 32-bit halves of the compare value. Both are writable and read back as written.
- R5: The control word at 0x2C has the enable at bit 0, the mask at bit 1 and the read-only status at bit 2. Bits 0 and 1 read back as written, and bits 31:3 read zero.
- R6: While enable is 1, status sets on the edge after the zero-extended count is greater than or equal to the 64-bit compare value, equality included. A compare value whose high half exceeds the count's range never sets it.
- R7: Once set, status stays set for as long as enable stays 1, even if the compare value is then raised above the count.
- R8: Writing enable to 0 drops `irq` in the cycle after the write edge and clears status on the following edge. Re-enabling does not restore a cleared status unless the compare condition holds again.
- R9: `irq` is high exactly when status is 1, enable is 1 and mask is 0. Setting the mask hides `irq` without touching status.
- R10: Reads of unmapped offsets return zero and writes to them change nothing. Writes to the count offsets 0x08 and 0x0C have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Count advance qualifier |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq | output | 1 | Level compare interrupt |

## Verification
A register write takes effect at the edge that samples it, and `irq` follows the enable and mask changes one half-cycle later, because it is a combinational gate on the registers. Status needs one more edge after the compare condition and the enable are both in place. Read data is registered, so it belongs to the edge that sampled the request. The bench drives every input on the falling edge and samples one falling edge after the relevant rising edge. It holds `tick` low while checking compare behaviour, which keeps the count fixed and gives each expected value an exact cycle. Counting and the no-stall property are checked by raising `tick` for a known number of edges and comparing the reads against a count tracked in the bench.

// File: rtl/syscnt_pkg.sv
package syscnt_pkg;
   localparam int unsigned BUS_W   = 32;
   localparam int unsigned CMP_W   = 64;

   // Software-visible byte offsets
   localparam int unsigned OFS_CNT_LO = 'h08;
   localparam int unsigned OFS_CNT_HI = 'h0C;
   localparam int unsigned OFS_CMP_LO = 'h20;
   localparam int unsigned OFS_CMP_HI = 'h24;
   localparam int unsigned OFS_CTRL   = 'h2C;

   // Control word bit positions
   localparam int unsigned CTL_EN   = 0;
   localparam int unsigned CTL_MASK = 1;
   localparam int unsigned CTL_STAT = 2;

   typedef enum logic [2:0] {
      SEL_NONE,
      SEL_CNT_LO,
      SEL_CNT_HI,
      SEL_CMP_LO,
      SEL_CMP_HI,
      SEL_CTRL
   } reg_sel_e;
endpackage

// File: rtl/syscnt_timebase.sv
module syscnt_timebase #(
   parameter int unsigned CNT_W = 56
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   output logic [CNT_W-1:0] cnt
);
   generate
      if (CNT_W < 33 || CNT_W > 64) begin : g_bad_width
         $error("syscnt_timebase: CNT_W must lie in 33..64");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (tick)
         cnt <= cnt + CNT_W'(1);
   end
endmodule

// File: rtl/syscnt_compare.sv
module syscnt_compare
   import syscnt_pkg::*;
#(
   parameter int unsigned CNT_W = 56
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] cnt,
   input  logic             wr_lo,
   input  logic             wr_hi,
   input  logic             wr_ctl,
   input  logic [BUS_W-1:0] wdata,
   output logic [CMP_W-1:0] cmp,
   output logic             en,
   output logic             mask,
   output logic             status
);
   localparam int unsigned HALF = CMP_W / 2;

   logic [CMP_W-1:0] cnt_ext;
   logic             hit;

   assign cnt_ext = CMP_W'(cnt);
   assign hit     = (cnt_ext >= cmp);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmp <= '0;
      end else begin
         if (wr_lo) cmp[HALF-1:0]     <= wdata;
         if (wr_hi) cmp[CMP_W-1:HALF] <= wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en   <= 1'b0;
         mask <= 1'b0;
      end else if (wr_ctl) begin
         en   <= wdata[CTL_EN];
         mask <= wdata[CTL_MASK];
      end
   end

   // Sticky flag; a low enable holds it cleared
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         status <= 1'b0;
      else if (!en)
         status <= 1'b0;
      else if (hit)
         status <= 1'b1;
   end
endmodule

// File: rtl/syscnt_regbus.sv
module syscnt_regbus
   import syscnt_pkg::*;
#(
   parameter int unsigned CNT_W  = 56,
   parameter int unsigned ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [CNT_W-1:0]  cnt,
   input  logic [CMP_W-1:0]  cmp,
   input  logic              en,
   input  logic              mask,
   input  logic              status,
   output logic              wr_lo,
   output logic              wr_hi,
   output logic              wr_ctl,
   output logic [BUS_W-1:0]  rdata
);
   localparam int unsigned HALF  = CMP_W / 2;
   localparam int unsigned UPPER = CNT_W - BUS_W;

   generate
      if (ADDR_W < 6) begin : g_bad_addr
         $error("syscnt_regbus: ADDR_W must reach offset 0x2C");
      end
   endgenerate

   reg_sel_e         sel;
   logic [BUS_W-1:0] cnt_hi_word;
   logic [BUS_W-1:0] ctl_word;
   logic [BUS_W-1:0] rmux;

   always_comb begin
      if      (bus_addr == ADDR_W'(OFS_CNT_LO)) sel = SEL_CNT_LO;
      else if (bus_addr == ADDR_W'(OFS_CNT_HI)) sel = SEL_CNT_HI;
      else if (bus_addr == ADDR_W'(OFS_CMP_LO)) sel = SEL_CMP_LO;
      else if (bus_addr == ADDR_W'(OFS_CMP_HI)) sel = SEL_CMP_HI;
      else if (bus_addr == ADDR_W'(OFS_CTRL))   sel = SEL_CTRL;
      else                                      sel = SEL_NONE;
   end

   generate
      if (UPPER == BUS_W) begin : g_full_hi
         assign cnt_hi_word = cnt[CNT_W-1:BUS_W];
      end else begin : g_ext_hi
         assign cnt_hi_word = {{(BUS_W-UPPER){1'b0}}, cnt[CNT_W-1:BUS_W]};
      end
   endgenerate

   always_comb begin
      ctl_word           = '0;
      ctl_word[CTL_EN]   = en;
      ctl_word[CTL_MASK] = mask;
      ctl_word[CTL_STAT] = status;
   end

   assign wr_lo  = bus_wr && (sel == SEL_CMP_LO);
   assign wr_hi  = bus_wr && (sel == SEL_CMP_HI);
   assign wr_ctl = bus_wr && (sel == SEL_CTRL);

   always_comb begin
      unique case (sel)
         SEL_CNT_LO: rmux = cnt[BUS_W-1:0];
         SEL_CNT_HI: rmux = cnt_hi_word;
         SEL_CMP_LO: rmux = cmp[HALF-1:0];
         SEL_CMP_HI: rmux = cmp[CMP_W-1:HALF];
         SEL_CTRL:   rmux = ctl_word;
         default:    rmux = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rdata <= '0;
      else if (bus_rd)
         rdata <= rmux;
   end
endmodule

// File: rtl/syscnt_top.sv
module syscnt_top
   import syscnt_pkg::*;
#(
   parameter int unsigned CNT_W  = 56,
   parameter int unsigned ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic              irq
);
   logic [CNT_W-1:0] cnt_q;
   logic [CMP_W-1:0] cmp_q;
   logic             ctl_en;
   logic             ctl_mask;
   logic             cmp_stat;
   logic             wr_lo;
   logic             wr_hi;
   logic             wr_ctl;

   syscnt_timebase #(.CNT_W(CNT_W)) u_tb (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick),
      .cnt   (cnt_q)
   );

   syscnt_compare #(.CNT_W(CNT_W)) u_cmp (
      .clk    (clk),
      .rst_n  (rst_n),
      .cnt    (cnt_q),
      .wr_lo  (wr_lo),
      .wr_hi  (wr_hi),
      .wr_ctl (wr_ctl),
      .wdata  (bus_wdata),
      .cmp    (cmp_q),
      .en     (ctl_en),
      .mask   (ctl_mask),
      .status (cmp_stat)
   );

   syscnt_regbus #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_bus (
      .clk      (clk),
      .rst_n    (rst_n),
      .bus_wr   (bus_wr),
      .bus_rd   (bus_rd),
      .bus_addr (bus_addr),
      .cnt      (cnt_q),
      .cmp      (cmp_q),
      .en       (ctl_en),
      .mask     (ctl_mask),
      .status   (cmp_stat),
      .wr_lo    (wr_lo),
      .wr_hi    (wr_hi),
      .wr_ctl   (wr_ctl),
      .rdata    (bus_rdata)
   );

   assign irq = cmp_stat & ctl_en & ~ctl_mask;
endmodule

// File: rtl/syscnt_chk.sv
module syscnt_chk #(
   parameter int unsigned CNT_W = 56
) (
   input logic             clk,
   input logic             rst_n,
   input logic             tick,
   input logic [CNT_W-1:0] cnt,
   input logic [63:0]      cmp,
   input logic             en,
   input logic             mask,
   input logic             status,
   input logic             irq
);
   // R2
   cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(tick)) |-> (cnt == $past(cnt) + CNT_W'(1)));

   // R2
   cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !$past(tick)) |-> $stable(cnt));

   // R6
   stat_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(en) && ($past(64'(cnt)) >= $past(cmp))) |-> status);

   // R7
   stat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(status) && $past(en)) |-> status);

   // R8
   stat_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !$past(en)) |-> !status);

   // R9
   irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (status && en && !mask));
endmodule

bind syscnt_top syscnt_chk #(.CNT_W(CNT_W)) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .tick   (tick),
   .cnt    (cnt_q),
   .cmp    (cmp_q),
   .en     (ctl_en),
   .mask   (ctl_mask),
   .status (cmp_stat),
   .irq    (irq)
);

// File: tb/sim_syscnt_top.sv
`timescale 1ns/1ps
module sim_syscnt_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick = 1'b0;
   logic        bus_wr = 1'b0;
   logic        bus_rd = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq;

   int   n_run = 0;
   int   n_bad = 0;
   bit   finished = 1'b0;
   logic [55:0] exp_cnt = '0;

   always #4 clk = ~clk;

   syscnt_top u0 (
      .clk(clk), .rst_n(rst_n), .tick(tick),
      .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_rd = 1'b1; bus_addr = a;
      @(negedge clk);
      bus_rd = 1'b0;
      d = bus_rdata;
   endtask

   task automatic t_reset();
      logic [31:0] v;
      rd(8'h08, v); chk("R1 cnt lo", v, 0);
      rd(8'h0C, v); chk("R1 cnt hi", v, 0);
      rd(8'h20, v); chk("R1 cmp lo", v, 0);
      rd(8'h24, v); chk("R1 cmp hi", v, 0);
      rd(8'h2C, v); chk("R1 ctrl", v, 0);
      chk("R1 irq", 32'(irq), 0);
   endtask

   task automatic t_count();
      logic [31:0] v1, v2;
      @(negedge clk); tick = 1'b1;
      repeat (20) @(negedge clk);
      tick = 1'b0;
      exp_cnt += 20;
      rd(8'h08, v1); chk("R2 count after 20 ticks", v1, exp_cnt[31:0]);
      rd(8'h0C, v1); chk("R3 hi word zero-extended", v1, 32'(exp_cnt[55:32]));
      // R2 R3: back-to-back live reads while ticking
      @(negedge clk);
      tick = 1'b1; bus_rd = 1'b1; bus_addr = 8'h08;
      @(negedge clk);
      v1 = bus_rdata;
      @(negedge clk);
      v2 = bus_rdata;
      tick = 1'b0; bus_rd = 1'b0;
      chk("R3 first live read", v1, exp_cnt[31:0]);
      chk("R2 no stall on read", v2, exp_cnt[31:0] + 1);
      exp_cnt += 2;
   endtask

   task automatic t_ignore();
      logic [31:0] v;
      wr(8'h08, 32'hFFFF_0000);
      wr(8'h0C, 32'h0000_00FF);
      rd(8'h08, v); chk("R10 cnt lo read-only", v, exp_cnt[31:0]);
      rd(8'h0C, v); chk("R10 cnt hi read-only", v, 0);
      wr(8'h28, 32'h0000_0003);
      wr(8'h10, 32'hABCD_1234);
      rd(8'h10, v); chk("R10 unmapped read", v, 0);
      rd(8'h2C, v); chk("R10 ctrl untouched", v, 0);
      rd(8'h21, v); chk("R10 misaligned read", v, 0);
      chk("R10 irq low", 32'(irq), 0);
   endtask

   task automatic t_cmpregs();
      logic [31:0] v;
      wr(8'h20, 32'hDEAD_BEEF);
      wr(8'h24, 32'h1234_5678);
      rd(8'h20, v); chk("R4 cmp lo", v, 32'hDEAD_BEEF);
      rd(8'h24, v); chk("R4 cmp hi", v, 32'h1234_5678);
      wr(8'h2C, 32'hFFFF_FFFF);
      @(negedge clk);
      rd(8'h2C, v); chk("R5 ctrl readback / R6 no fire above range", v, 32'h3);
      wr(8'h2C, 32'h0);
      rd(8'h2C, v); chk("R5 ctrl cleared", v, 0);
   endtask

   task automatic t_fire();
      logic [31:0] v;
      logic [55:0] tgt;
      tgt = exp_cnt + 5;
      wr(8'h24, 32'h0);
      wr(8'h20, tgt[31:0]);
      wr(8'h2C, 32'h1);
      @(negedge clk);
      rd(8'h2C, v); chk("R6 below compare", v, 32'h1);
      chk("R6 irq low below", 32'(irq), 0);
      @(negedge clk); tick = 1'b1;
      repeat (5) @(negedge clk);
      tick = 1'b0; exp_cnt += 5;
      @(negedge clk);
      chk("R6 irq at equality", 32'(irq), 1);
      rd(8'h2C, v); chk("R6 status set", v, 32'h5);
      wr(8'h20, 32'hFFFF_FFFF);
      @(negedge clk);
      rd(8'h2C, v); chk("R7 status sticky", v, 32'h5);
      chk("R7 irq held", 32'(irq), 1);
      wr(8'h2C, 32'h3);
      chk("R9 mask hides irq", 32'(irq), 0);
      rd(8'h2C, v); chk("R9 mask keeps status", v, 32'h7);
      wr(8'h2C, 32'h1);
      chk("R9 unmask restores irq", 32'(irq), 1);
      wr(8'h2C, 32'h0);
      chk("R8 irq drops on disable", 32'(irq), 0);
      rd(8'h2C, v); chk("R8 status cleared", v, 0);
      wr(8'h2C, 32'h1);
      @(negedge clk);
      rd(8'h2C, v); chk("R8 re-enable stays clear", v, 32'h1);
      chk("R8 irq stays low", 32'(irq), 0);
      wr(8'h2C, 32'h0);
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
         $finish;
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_count();
      t_ignore();
      t_cmpregs();
      t_fire();
      finish_run();
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_run++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end
endmodule